// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Parking Policy

This block decides which of up to seven bus masters owns one slave port of a multi-layer AHB-Lite interconnect. Each master presents a request, a lock flag, a beat strobe and a last-beat flag. The arbiter holds one registered owner and drives a one-hot grant, the owner's index and the owner's lock flag toward the slave. Address decoding, the data path and the configuration registers sit outside the block and reach it as plain configuration inputs.

Two arbitration schemes are available. Rotating selection searches upward from the index after the last winner. Priority selection compares a 2-bit level per master. When nobody requests, a parking policy decides what happens to the slave. It can be released, left with its most recent owner, or handed to a programmed master. A parked master that raises its request already holds the grant, so it pays no arbitration cycle. Any other master is granted on the clock edge after its request is first sampled. A beat counter cuts bursts that never signal a last beat at 32, 64, 128 or 256 beats and forces a new arbitration there. A locked owner is never displaced.

Top module: `ahb_slv_arb`

## Requirements
- R1: After reset no master is granted: `grant` is all zero, and `grant_vld` and `slv_lock` are low.
- R2: `grant` has at most one bit set. When `grant_vld` is high, the set bit is bit `slv_master`.
- R3: A master that does not own the slave and raises `m_req` while the slave is free is granted at the first clock edge after the request is sampled. A parked owner that raises `m_req` is already granted in that cycle.
- R4: With `cfg_rr_en`=1, the winner is the first requesting index found by searching upward, with wrap-around, from the index after the most recent winner. Right after reset the search starts at index 0.
- R5: With `cfg_rr_en`=0, the winner is the requester with the largest level in `cfg_prio[2i+1:2i]`. On equal levels the lowest index wins.
- R6: With `cfg_park_mode`=0 or 3, the grant is dropped at the next edge when no master requests and the owner's lock is low.
- R7: With `cfg_park_mode`=1, an idle slave stays granted to its current owner.
- R8: With `cfg_park_mode`=2, an idle slave is granted to master `cfg_park_idx`. An index of NM or above parks on master 0.
- R9: While the owner keeps `m_req` high, ownership moves only after a beat (`m_beat` high) that either carries `m_last` or is the length-limit beat.
- R10: `cfg_beat_sel` values 0, 1, 2 and 3 give limits of 32, 64, 128 and 256 beats. After that many beats without `m_last`, arbitration runs again.
- R11: While the owner's `m_lock` is high, the owner keeps the grant, even across last beats and the length limit. `slv_lock` shows the owner's `m_lock`.
- R12: `slv_master` carries the index of the granted master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rr_en | input | 1 | 1 = rotating selection, 0 = priority selection |
| cfg_park_mode | input | 2 | 0/3 release, 1 keep last owner, 2 park on fixed master |
| cfg_park_idx | input | IW | Master to park on in mode 2 |
| cfg_prio | input | 2*NM | 2-bit priority level per master |
| cfg_beat_sel | input | 2 | Burst length limit select (32 << value) |
| m_req | input | NM | Per-master request for this slave |
| m_lock | input | NM | Per-master lock flag |
| m_beat | input | NM | Per-master beat accepted this cycle |
| m_last | input | NM | Per-master flag marking the last beat of a burst |
| grant | output | NM | One-hot grant |
| grant_vld | output | 1 | Some master owns the slave |
| slv_master | output | IW | Index of the owner, forwarded to the slave |
| slv_lock | output | 1 | Owner's lock flag, forwarded to the slave |

## Verification
The bench walks rotating order across the wrap point and priority ties. An off-by-one in the search start, or a tie broken toward the higher index, would hand the grant to the wrong master. It runs exactly 31 and 32 beats, then 63 and 64 beats, without a last flag. A counter that compares against the wrong value would move the grant one beat early or late. It holds lock through last beats and past the beat limit, where a design that ignores lock would hand the slave away. It also checks that a parked master is already granted when it requests, while a fresh requester waits one edge. A design that parks wrongly would show zero latency in both cases, or in neither.

// File: rtl/ahb_arb_pkg.sv
package ahb_arb_pkg;
  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2
  } park_e;

  localparam int unsigned BEAT_CAP = 256;

  // Beats allowed in one burst for a limit select code.
  function automatic int unsigned beat_limit(input logic [1:0] sel);
    return 32 << sel;
  endfunction
endpackage

// File: rtl/ahb_arb_pick.sv
module ahb_arb_pick #(
  parameter  int NM = 7,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [NM-1:0]   req,
  input  logic            rr_mode,
  input  logic [IW-1:0]   last_idx,
  input  logic [2*NM-1:0] prio,
  output logic            any,
  output logic [IW-1:0]   win
);
  logic [IW-1:0] rr_w, fp_w, rr_pos;
  logic          rr_hit, fp_hit;
  logic [1:0]    fp_lvl;

  // Rotating search: start after the most recent winner.
  always_comb begin
    rr_w   = '0;
    rr_hit = 1'b0;
    rr_pos = '0;
    for (int k = 1; k <= NM; k++) begin
      rr_pos = IW'((int'(last_idx) + k) % NM);
      if (!rr_hit && req[rr_pos]) begin
        rr_hit = 1'b1;
        rr_w   = rr_pos;
      end
    end
  end

  // Priority search: strict compare keeps ties with the lower index.
  always_comb begin
    fp_w   = '0;
    fp_hit = 1'b0;
    fp_lvl = '0;
    for (int j = 0; j < NM; j++) begin
      if (req[j] && (!fp_hit || prio[2*j +: 2] > fp_lvl)) begin
        fp_hit = 1'b1;
        fp_lvl = prio[2*j +: 2];
        fp_w   = IW'(j);
      end
    end
  end

  assign any = |req;
  assign win = rr_mode ? rr_w : fp_w;
endmodule

// File: rtl/ahb_arb_beat_cnt.sv
module ahb_arb_beat_cnt
  import ahb_arb_pkg::*;
#(
  parameter  int CAP = BEAT_CAP,
  localparam int CW  = $clog2(CAP) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       beat,
  input  logic       last,
  input  logic [1:0] sel,
  output logic       hit
);
  logic [CW-1:0] cnt_q;

  assign hit = beat && (cnt_q == CW'(beat_limit(sel) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (beat) begin
      if (last || hit)       cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ahb_arb_park.sv
module ahb_arb_park
  import ahb_arb_pkg::*;
#(
  parameter  int NM = 7,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [1:0]    mode,
  input  logic [IW-1:0] fix_idx,
  input  logic          cur_vld,
  input  logic [IW-1:0] cur_idx,
  output logic          nxt_vld,
  output logic [IW-1:0] nxt_idx
);
  always_comb begin
    nxt_vld = 1'b0;
    nxt_idx = cur_idx;
    case (park_e'(mode))
      PARK_LAST: begin
        nxt_vld = cur_vld;
        nxt_idx = cur_idx;
      end
      PARK_FIXED: begin
        nxt_vld = 1'b1;
        nxt_idx = (int'(fix_idx) < NM) ? fix_idx : '0;
      end
      default: begin
        nxt_vld = 1'b0;
        nxt_idx = cur_idx;
      end
    endcase
  end
endmodule

// File: rtl/ahb_slv_arb.sv
module ahb_slv_arb
  import ahb_arb_pkg::*;
#(
  parameter  int NM = 7,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_rr_en,
  input  logic [1:0]      cfg_park_mode,
  input  logic [IW-1:0]   cfg_park_idx,
  input  logic [2*NM-1:0] cfg_prio,
  input  logic [1:0]      cfg_beat_sel,
  input  logic [NM-1:0]   m_req,
  input  logic [NM-1:0]   m_lock,
  input  logic [NM-1:0]   m_beat,
  input  logic [NM-1:0]   m_last,
  output logic [NM-1:0]   grant,
  output logic            grant_vld,
  output logic [IW-1:0]   slv_master,
  output logic            slv_lock
);
  logic          own_vld_q;
  logic [IW-1:0] own_q, last_q;

  // Named events of the current owner, also watched by the checker.
  logic own_req, own_lock, own_beat, own_last;
  logic lim_hit, burst_end, slot_free;
  logic win_any;
  logic [IW-1:0] win_idx;
  logic park_vld;
  logic [IW-1:0] park_idx_n;

  assign own_req   = own_vld_q && m_req[own_q];
  assign own_lock  = own_vld_q && m_lock[own_q];
  assign own_beat  = own_vld_q && m_beat[own_q];
  assign own_last  = m_last[own_q];
  assign burst_end = own_beat && (own_last || lim_hit);
  assign slot_free = !own_vld_q || (!own_lock && (!own_req || burst_end));

  ahb_arb_pick #(.NM(NM)) u_pick (
    .req      (m_req),
    .rr_mode  (cfg_rr_en),
    .last_idx (last_q),
    .prio     (cfg_prio),
    .any      (win_any),
    .win      (win_idx)
  );

  ahb_arb_beat_cnt #(.CAP(BEAT_CAP)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (slot_free),
    .beat  (own_beat),
    .last  (own_last),
    .sel   (cfg_beat_sel),
    .hit   (lim_hit)
  );

  ahb_arb_park #(.NM(NM)) u_park (
    .mode    (cfg_park_mode),
    .fix_idx (cfg_park_idx),
    .cur_vld (own_vld_q),
    .cur_idx (own_q),
    .nxt_vld (park_vld),
    .nxt_idx (park_idx_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_q     <= '0;
      last_q    <= IW'(NM - 1);
    end else if (slot_free) begin
      if (win_any) begin
        own_vld_q <= 1'b1;
        own_q     <= win_idx;
        last_q    <= win_idx;
      end else begin
        own_vld_q <= park_vld;
        own_q     <= park_idx_n;
      end
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_gnt
    assign grant[i] = own_vld_q && (own_q == IW'(i));
  end

  assign grant_vld  = own_vld_q;
  assign slv_master = own_q;
  assign slv_lock   = own_lock;
endmodule

// File: rtl/ahb_slv_arb_chk.sv
module ahb_slv_arb_chk #(
  parameter  int NM = 7,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_park_mode,
  input logic [IW-1:0] cfg_park_idx,
  input logic [NM-1:0] m_req,
  input logic [NM-1:0] grant,
  input logic          grant_vld,
  input logic [IW-1:0] slv_master,
  input logic          slv_lock,
  input logic          own_req,
  input logic          burst_end
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_index_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> grant[slv_master]);

  a_r9_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && own_req && !burst_end) |=> (grant_vld && $stable(slv_master)));

  a_r11_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && slv_lock) |=> (grant_vld && $stable(slv_master)));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_park_mode == 2'd0 && m_req == '0 && !slv_lock) |=> !grant_vld);

  a_r7_keep_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_park_mode == 2'd1 && m_req == '0 && grant_vld) |=> (grant_vld && $stable(slv_master)));

  a_r8_fixed_park: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_park_mode == 2'd2 && m_req == '0 && !slv_lock && int'(cfg_park_idx) < NM)
      |=> (grant_vld && slv_master == $past(cfg_park_idx)));
endmodule

bind ahb_slv_arb ahb_slv_arb_chk #(.NM(NM)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_park_mode (cfg_park_mode),
  .cfg_park_idx  (cfg_park_idx),
  .m_req         (m_req),
  .grant         (grant),
  .grant_vld     (grant_vld),
  .slv_master    (slv_master),
  .slv_lock      (slv_lock),
  .own_req       (own_req),
  .burst_end     (burst_end)
);

// File: tb/test_ahb_slv_arb.sv
`timescale 1ns/1ps
module test_ahb_slv_arb;
  localparam int NM = 7;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_rr_en = 1'b1;
  logic [1:0]      cfg_park_mode = 2'd0;
  logic [IW-1:0]   cfg_park_idx = '0;
  logic [2*NM-1:0] cfg_prio = '0;
  logic [1:0]      cfg_beat_sel = 2'd0;
  logic [NM-1:0]   m_req = '0, m_lock = '0, m_beat = '0, m_last = '0;
  logic [NM-1:0]   grant;
  logic            grant_vld;
  logic [IW-1:0]   slv_master;
  logic            slv_lock;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  vld;
    int    idx;
    logic  lk;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;

  always #2.5 clk = ~clk;

  ahb_slv_arb #(.NM(NM)) i_ahb_slv_arb (
    .clk(clk), .rst_n(rst_n), .cfg_rr_en(cfg_rr_en), .cfg_park_mode(cfg_park_mode),
    .cfg_park_idx(cfg_park_idx), .cfg_prio(cfg_prio), .cfg_beat_sel(cfg_beat_sel),
    .m_req(m_req), .m_lock(m_lock), .m_beat(m_beat), .m_last(m_last),
    .grant(grant), .grant_vld(grant_vld), .slv_master(slv_master), .slv_lock(slv_lock)
  );

  function automatic logic [NM-1:0] onehot_of(input logic v, input int i);
    logic [NM-1:0] r;
    r = '0;
    if (v) r[i] = 1'b1;
    return r;
  endfunction

  // Monitor: compares each expected item just after the edge it belongs to.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      mon_e = exp_q.pop_front();
      checks++;
      if (grant_vld !== mon_e.vld || (mon_e.vld && int'(slv_master) != mon_e.idx)
          || slv_lock !== mon_e.lk) begin
        errors++;
        $display("FAIL %s: vld/master/lock actual %0b/%0d/%0b expected %0b/%0d/%0b",
                 mon_e.tag, grant_vld, slv_master, slv_lock, mon_e.vld, mon_e.idx, mon_e.lk);
      end
      checks++;
      if (grant !== onehot_of(mon_e.vld, mon_e.idx)) begin
        errors++;
        $display("FAIL R2 (%s): grant actual %b expected %b",
                 mon_e.tag, grant, onehot_of(mon_e.vld, mon_e.idx));
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue the state expected after the edge.
  task automatic cyc(input logic [NM-1:0] rq, input logic [NM-1:0] lk,
                     input logic [NM-1:0] bt, input logic [NM-1:0] ls,
                     input logic ev, input int ei, input logic el, input string tag);
    exp_t e;
    m_req = rq; m_lock = lk; m_beat = bt; m_last = ls;
    e.vld = ev; e.idx = ei; e.lk = el; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Check the current registered grant before the next edge.
  task automatic chk_now(input logic ev, input int ei, input string tag);
    #1;
    checks++;
    if (grant_vld !== ev || (ev && int'(slv_master) != ei)) begin
      errors++;
      $display("FAIL %s: vld/master actual %0b/%0d expected %0b/%0d",
               tag, grant_vld, slv_master, ev, ei);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (grant !== '0 || grant_vld !== 1'b0 || slv_lock !== 1'b0) begin
      errors++;
      $display("FAIL R1: grant/vld/lock actual %b/%0b/%0b expected 0/0/0",
               grant, grant_vld, slv_lock);
    end

    // R3 / R6 / R12: one-cycle grant, single beats, release when idle.
    m_req = 7'b0000100;
    chk_now(1'b0, 0, "R3 not granted before edge");
    cyc(7'b0000100, '0, '0, '0, 1'b1, 2, 1'b0, "R3 grant one edge later");
    cyc(7'b0000100, '0, 7'h7f, 7'h7f, 1'b1, 2, 1'b0, "R12 owner index");
    cyc('0, '0, '0, '0, 1'b0, 0, 1'b0, "R6 release when idle");

    // R4: rotating order starting after last winner (2).
    cyc(7'b0100011, '0, '0, '0, 1'b1, 5, 1'b0, "R4 start after last");
    cyc(7'b0100011, '0, 7'h7f, 7'h7f, 1'b1, 0, 1'b0, "R4 wrap");
    cyc(7'b0100011, '0, 7'h7f, 7'h7f, 1'b1, 1, 1'b0, "R4 next");
    cyc(7'b0100011, '0, 7'h7f, 7'h7f, 1'b1, 5, 1'b0, "R4 back to 5");
    cyc('0, '0, '0, '0, 1'b0, 0, 1'b0, "R6 release");

    // R5: priority levels m1=1, m3=3, m4=3, m6=2.
    cfg_rr_en = 1'b0;
    cfg_prio  = 14'b10_11_11_00_01_01_00;
    cfg_prio[3:2] = 2'd1;
    cfg_prio[1:0] = 2'd0;
    cfg_prio[5:4] = 2'd0;
    cfg_prio[7:6] = 2'd3;
    cfg_prio[9:8] = 2'd3;
    cfg_prio[11:10] = 2'd0;
    cfg_prio[13:12] = 2'd2;
    cyc(7'b1011010, '0, '0, '0, 1'b1, 3, 1'b0, "R5 tie to lower index");
    cyc(7'b1011010, '0, 7'h7f, 7'h7f, 1'b1, 3, 1'b0, "R5 top keeps winning");
    cyc(7'b1010010, '0, 7'h7f, 7'h7f, 1'b1, 4, 1'b0, "R5 next level 3");
    cyc(7'b1000010, '0, 7'h7f, 7'h7f, 1'b1, 6, 1'b0, "R5 level 2");
    cyc(7'b0000010, '0, 7'h7f, 7'h7f, 1'b1, 1, 1'b0, "R5 level 1");
    cyc('0, '0, '0, '0, 1'b0, 0, 1'b0, "R6 release");

    // R7 and zero-latency part of R3.
    cfg_rr_en = 1'b1;
    cfg_park_mode = 2'd1;
    cyc(7'b0010000, '0, '0, '0, 1'b1, 4, 1'b0, "R3 grant m4");
    cyc('0, '0, '0, '0, 1'b1, 4, 1'b0, "R7 keep last owner");
    cyc('0, '0, '0, '0, 1'b1, 4, 1'b0, "R7 still parked");
    m_req = 7'b0010000;
    chk_now(1'b1, 4, "R3 parked owner zero latency");
    cyc(7'b0010000, '0, '0, '0, 1'b1, 4, 1'b0, "R3 parked owner stays");
    m_req = 7'b1000000;
    chk_now(1'b1, 4, "R3 other master waits");
    cyc(7'b1000000, '0, '0, '0, 1'b1, 6, 1'b0, "R3 other master one edge later");
    cyc('0, '0, '0, '0, 1'b1, 6, 1'b0, "R7 keeps new owner");

    // R8: fixed parking, out-of-range index, code 3 behaves as release.
    cfg_park_mode = 2'd2;
    cfg_park_idx  = 3'd3;
    cyc('0, '0, '0, '0, 1'b1, 3, 1'b0, "R8 park fixed");
    cfg_park_idx  = 3'd7;
    cyc('0, '0, '0, '0, 1'b1, 0, 1'b0, "R8 out of range parks on 0");
    cfg_park_mode = 2'd3;
    cyc('0, '0, '0, '0, 1'b0, 0, 1'b0, "R6 code 3 releases");

    // R9 / R10: limit 32 cuts an endless burst.
    cfg_park_mode = 2'd0;
    cfg_beat_sel  = 2'd0;
    cyc(7'b0000010, '0, '0, '0, 1'b1, 1, 1'b0, "R10 grant m1");
    for (int b = 1; b <= 32 * (2 ** 0); b++)
      cyc(7'b0000110, '0, 7'b0000010, '0, 1'b1, (b < 32) ? 1 : 2, 1'b0,
          (b < 32) ? "R10 held below limit 32" : "R10 cut at 32 beats");
    for (int b = 0; b < 3; b++)
      cyc(7'b0000110, '0, 7'b0000100, '0, 1'b1, 2, 1'b0, "R9 mid burst hold");
    cyc(7'b0000110, '0, 7'b0000100, 7'b0000100, 1'b1, 1, 1'b0, "R9 move after last beat");
    cyc('0, '0, '0, '0, 1'b0, 0, 1'b0, "R6 release");

    // R10: limit 64.
    cfg_beat_sel = 2'd1;
    cyc(7'b0001000, '0, '0, '0, 1'b1, 3, 1'b0, "R10 grant m3");
    for (int b = 1; b <= 32 * (2 ** 1); b++)
      cyc(7'b0011000, '0, 7'b0001000, '0, 1'b1, (b < 64) ? 3 : 4, 1'b0,
          (b < 64) ? "R10 held below limit 64" : "R10 cut at 64 beats");
    cyc('0, '0, '0, '0, 1'b0, 0, 1'b0, "R6 release");

    // R11: lock holds through last beats and past the limit.
    cfg_beat_sel = 2'd0;
    cyc(7'b0000001, 7'b0000001, '0, '0, 1'b1, 0, 1'b1, "R11 locked grant");
    for (int b = 0; b < 3; b++)
      cyc(7'b0100001, 7'b0000001, 7'b0000001, 7'b0000001, 1'b1, 0, 1'b1, "R11 lock over last");
    for (int b = 0; b < 33; b++)
      cyc(7'b0100001, 7'b0000001, 7'b0000001, '0, 1'b1, 0, 1'b1, "R11 lock over limit");
    cyc(7'b0100001, '0, 7'b0000001, 7'b0000001, 1'b1, 5, 1'b0, "R11 move after unlock");
    cyc('0, '0, '0, '0, 1'b0, 0, 1'b0, "R6 release");

    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule